// File: doc/BRIEF.md
# Stream Buffer Descriptor Position Tracker

This block keeps the per-stream transfer position for an audio controller with four input streams (indices 0 to 3) and four output streams (indices 4 to 7). Software programs each stream with a descriptor list base, a last-valid-index and a control word that carries a run bit and a stream tag. When a stream starts, the block reads the first descriptor from memory. It then serves word requests from the codec side. Each request is matched to a running stream by direction and tag, and one 32-bit word moves between the codec port and memory at the current descriptor address plus the in-entry offset.

After every word the block advances the in-entry offset and the link position. It crosses descriptor boundaries and fetches the next entry on demand. It raises a completion flag for entries marked interrupt-on-completion, and it wraps to the start of the list after the last entry. The link position can be read at its normal register and at an alias 0x2000 higher. When enabled, the position is also written to a position buffer in memory with an 8-byte slot per stream.

One engine state machine serves all eight streams. Its states are IDLE, FETCH_ADR, FETCH_LEN, FETCH_FLG, MOVE, POSWR and REFUSE. IDLE goes to FETCH_ADR when any stream has a pending descriptor fetch; fetch has priority. Otherwise IDLE goes to MOVE when a word request matches a running stream, and to REFUSE when it matches none. FETCH_ADR goes to FETCH_LEN, FETCH_LEN to FETCH_FLG, and FETCH_FLG back to IDLE, each step on a memory acknowledge. MOVE goes to POSWR on acknowledge when the position buffer is enabled, and to IDLE otherwise. POSWR goes to IDLE on acknowledge, and REFUSE returns to IDLE after one cycle.

Top module: `stream_pos_tracker`

## Requirements
- R1: After reset, every stream reads control 0, position 0, status 0, last-valid-index 0 and list base 0. No memory request is made, and there is no acknowledge or refusal on the codec port.
- R2: When a stream starts, the block reads the descriptor at list base + 16*entry index. It takes the buffer address from offset +0, the length in bytes from +8 and the completion flag from bit 0 of +12. The word at +4 is not used.
- R3: An accepted request moves exactly one word in one acknowledge cycle. An output-direction request (xfer_dir=1, streams 4 to 7) returns the memory word at buffer address + offset on xfer_rdata. An input-direction request (xfer_dir=0, streams 0 to 3) writes xfer_wdata there. Acknowledges never occur in two consecutive cycles.
- R4: Each moved word adds 4 to the in-entry offset and to the link position. Stream i has its register window at 0x80 + 0x20*i, and the link position is read at window offset +0x04.
- R5: When the offset reaches the entry length, the offset returns to 0, the next descriptor is fetched, and status bit 2 is set, but only if the completed entry's flag is set.
- R6: When the completed entry is the last one (index equal to the last-valid-index at window offset +0x0C), the entry index and the link position both return to 0.
- R7: A request is routed to the lowest-index running stream whose direction matches xfer_dir and whose tag (control bits 23:20) equals xfer_tag. Streams of the other direction are not touched.
- R8: A request with tag 0, or with no matching running stream, is answered with xfer_err for one cycle. It makes no memory access and changes no position.
- R9: Reading address 0x2000 + (window + 0x04) returns the same value as the link position register.
- R10: The configuration register at 0x70 holds enable in bit 0 and base in bits 31:3. When enabled, after each moved word the block writes the new link position of stream i to base + 8*i.
- R11: Writing control (window +0x00) with bit 0 set clears the stream's run bit, tag, position, last-valid-index, list base and completion flag, and sets status bit 5. Control then reads back bit 0 as 1 until control is written with bit 0 clear.
- R12: A 0-to-1 change of control bit 1 (run) sets the link position to 0 and restarts the stream from entry 0. While run is 0 the stream accepts no transfers.
- R13: Writing status (window +0x08) with bit 2 set clears the completion flag. Writing 0 to that bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 14 | Register write byte address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 14 | Register read byte address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| xfer_req | input | 1 | Codec word request, held until ack or err |
| xfer_dir | input | 1 | 0 = input stream (codec to memory), 1 = output stream |
| xfer_tag | input | 4 | Stream tag of the request |
| xfer_wdata | input | 32 | Word from the codec for input streams |
| xfer_ack | output | 1 | Word moved this cycle |
| xfer_err | output | 1 | Request refused |
| xfer_rdata | output | 32 | Word to the codec for output streams, valid with xfer_ack |

## Verification
The hardest case to reach from the ports is a word that completes the last entry of a list. That one acknowledge must wrap the index, zero the position, set the completion flag only for a flagged entry, and trigger a new descriptor fetch before the next word is served. The stimulus builds short lists with 4- and 8-byte entries, so a few requests reach the end of the list. The next returned word must come from the first entry again. A position-buffer write must record 0 at the wrap, and the same tag is used on a stream of the other direction to show that routing does not cross directions.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        EN_IDLE,
        EN_FETCH_ADR,
        EN_FETCH_LEN,
        EN_FETCH_FLG,
        EN_MOVE,
        EN_POSWR,
        EN_REFUSE
    } eng_state_e;

    typedef enum logic [2:0] {
        FLD_CTL,
        FLD_POS,
        FLD_STS,
        FLD_LVI,
        FLD_BASE,
        FLD_NONE
    } reg_fld_e;

endpackage

// File: rtl/spt_addr_dec.sv
module spt_addr_dec
    import spt_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NS        = 8,
    parameter int WIN_BASE  = 'h80,
    parameter int ALIAS_OFF = 'h2000,
    localparam int SEL_W    = $clog2(NS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              is_alias,
    output logic [SEL_W-1:0]  idx,
    output reg_fld_e          fld
);
    localparam logic [ADDR_W-1:0] ALIAS_A = ADDR_W'(ALIAS_OFF);
    localparam logic [ADDR_W-1:0] WIN_A   = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A  = ADDR_W'(NS * 32);

    logic [ADDR_W-1:0] local_a;
    logic [ADDR_W-1:0] rel;
    logic              in_win;

    always_comb begin
        is_alias = (addr >= ALIAS_A);
        local_a  = is_alias ? (addr - ALIAS_A) : addr;
        rel      = local_a - WIN_A;
        in_win   = (local_a >= WIN_A) && (rel < SPAN_A);
        idx      = rel[SEL_W+4:5];
        unique case (rel[4:0])
            5'h00:   fld = FLD_CTL;
            5'h04:   fld = FLD_POS;
            5'h08:   fld = FLD_STS;
            5'h0C:   fld = FLD_LVI;
            5'h10:   fld = FLD_BASE;
            default: fld = FLD_NONE;
        endcase
        hit = in_win && (fld != FLD_NONE) && (!is_alias || fld == FLD_POS);
    end
endmodule

// File: rtl/spt_lane.sv
module spt_lane
    import spt_pkg::*;
#(
    parameter int LVI_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_fld_e    wr_fld,
    input  logic [31:0] wr_data,
    input  logic        ld,
    input  logic [31:0] ld_addr,
    input  logic [31:0] ld_len,
    input  logic        ld_ioc,
    input  logic        step,
    output logic        run,
    output logic [3:0]  tag,
    output logic        need_fetch,
    output logic [31:0] lpib,
    output logic [31:0] cur_addr,
    output logic [31:0] fetch_addr,
    output logic [31:0] ctl_word,
    output logic [31:0] sts_word,
    output logic [31:0] lvi_word,
    output logic [31:0] base_word
);
    logic             srst_q, bcis_q, fifordy_q, ioc_q;
    logic [LVI_W-1:0] lvi_q, idx_q;
    logic [31:0]      base_q, off_q, ent_addr_q, ent_len_q;
    logic [31:0]      off_inc;
    logic             end_of_ent, end_of_list;

    always_comb begin
        off_inc     = off_q + 32'd4;
        end_of_ent  = (off_inc == ent_len_q);
        end_of_list = (idx_q == lvi_q);
        cur_addr    = ent_addr_q + off_q;
        fetch_addr  = base_q + (32'(idx_q) << 4);
        ctl_word    = {8'h00, tag, 18'h0, run, srst_q};
        sts_word    = {26'h0, fifordy_q, 2'b00, bcis_q, 2'b00};
        lvi_word    = 32'(lvi_q);
        base_word   = base_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0; tag <= '0; srst_q <= 1'b0; bcis_q <= 1'b0;
            fifordy_q <= 1'b0; ioc_q <= 1'b0; lvi_q <= '0; idx_q <= '0;
            base_q <= '0; off_q <= '0; lpib <= '0; need_fetch <= 1'b0;
            ent_addr_q <= '0; ent_len_q <= '0;
        end else begin
            if (ld) begin
                ent_addr_q <= ld_addr;
                ent_len_q  <= ld_len;
                ioc_q      <= ld_ioc;
                need_fetch <= 1'b0;
            end
            if (step) begin
                if (end_of_ent) begin
                    off_q      <= '0;
                    need_fetch <= 1'b1;
                    if (ioc_q) bcis_q <= 1'b1;
                    if (end_of_list) begin
                        idx_q <= '0;
                        lpib  <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        lpib  <= lpib + 32'd4;
                    end
                end else begin
                    off_q <= off_inc;
                    lpib  <= lpib + 32'd4;
                end
            end
            if (wr_en) begin
                unique case (wr_fld)
                    FLD_CTL: begin
                        if (wr_data[0]) begin
                            run <= 1'b0; tag <= '0; srst_q <= 1'b1;
                            fifordy_q <= 1'b1; bcis_q <= 1'b0; ioc_q <= 1'b0;
                            lvi_q <= '0; idx_q <= '0; base_q <= '0;
                            off_q <= '0; lpib <= '0; need_fetch <= 1'b0;
                            ent_addr_q <= '0; ent_len_q <= '0;
                        end else begin
                            srst_q <= 1'b0;
                            tag    <= wr_data[23:20];
                            run    <= wr_data[1];
                            if (wr_data[1] && !run) begin
                                lpib <= '0; off_q <= '0; idx_q <= '0;
                                need_fetch <= 1'b1;
                            end
                            if (!wr_data[1]) need_fetch <= 1'b0;
                        end
                    end
                    FLD_STS:  if (wr_data[2]) bcis_q <= 1'b0;
                    FLD_LVI:  lvi_q  <= wr_data[LVI_W-1:0];
                    FLD_BASE: base_q <= {wr_data[31:2], 2'b00};
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spt_engine.sv
module spt_engine
    import spt_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    localparam int NS    = N_IN + N_OUT,
    localparam int SEL_W = $clog2(NS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NS-1:0]        need_fetch,
    input  logic [NS-1:0]        run,
    input  logic [NS-1:0][3:0]   tag,
    input  logic [NS-1:0][31:0]  cur_addr,
    input  logic [NS-1:0][31:0]  fetch_addr,
    input  logic [NS-1:0][31:0]  lpib,
    input  logic                 pb_en,
    input  logic [31:0]          pb_base,
    input  logic                 xfer_req,
    input  logic                 xfer_dir,
    input  logic [3:0]           xfer_tag,
    input  logic [31:0]          xfer_wdata,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [31:0]          mem_addr,
    output logic [31:0]          mem_wdata,
    output logic [NS-1:0]        ld,
    output logic [31:0]          ld_addr,
    output logic [31:0]          ld_len,
    output logic                 ld_ioc,
    output logic [NS-1:0]        step,
    output logic                 xfer_ack,
    output logic                 xfer_err,
    output logic [31:0]          xfer_rdata
);
    eng_state_e       state, nxt;
    logic [SEL_W-1:0] sel_q, fetch_sel, route_sel;
    logic             fetch_any, route_hit;
    logic [31:0]      adr_q, len_q;

    always_comb begin
        fetch_any = 1'b0;
        fetch_sel = '0;
        route_hit = 1'b0;
        route_sel = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (need_fetch[i]) begin
                fetch_any = 1'b1;
                fetch_sel = SEL_W'(i);
            end
            if (run[i] && tag[i] == xfer_tag && xfer_tag != 4'd0 &&
                ((i >= N_IN) == xfer_dir)) begin
                route_hit = 1'b1;
                route_sel = SEL_W'(i);
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            EN_IDLE: begin
                if (fetch_any)     nxt = EN_FETCH_ADR;
                else if (xfer_req) nxt = route_hit ? EN_MOVE : EN_REFUSE;
            end
            EN_FETCH_ADR: if (mem_ack) nxt = EN_FETCH_LEN;
            EN_FETCH_LEN: if (mem_ack) nxt = EN_FETCH_FLG;
            EN_FETCH_FLG: if (mem_ack) nxt = EN_IDLE;
            EN_MOVE:      if (mem_ack) nxt = pb_en ? EN_POSWR : EN_IDLE;
            EN_POSWR:     if (mem_ack) nxt = EN_IDLE;
            EN_REFUSE:    nxt = EN_IDLE;
            default:      nxt = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= EN_IDLE;
            sel_q <= '0;
            adr_q <= '0;
            len_q <= '0;
        end else begin
            state <= nxt;
            if (state == EN_IDLE) sel_q <= fetch_any ? fetch_sel : route_sel;
            if (state == EN_FETCH_ADR && mem_ack) adr_q <= mem_rdata;
            if (state == EN_FETCH_LEN && mem_ack) len_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        ld         = '0;
        ld_addr    = adr_q;
        ld_len     = len_q;
        ld_ioc     = mem_rdata[0];
        step       = '0;
        xfer_ack   = 1'b0;
        xfer_err   = 1'b0;
        xfer_rdata = '0;
        unique case (state)
            EN_IDLE: ;
            EN_FETCH_ADR: begin
                mem_req  = 1'b1;
                mem_addr = fetch_addr[sel_q];
            end
            EN_FETCH_LEN: begin
                mem_req  = 1'b1;
                mem_addr = fetch_addr[sel_q] + 32'd8;
            end
            EN_FETCH_FLG: begin
                mem_req    = 1'b1;
                mem_addr   = fetch_addr[sel_q] + 32'd12;
                ld[sel_q]  = mem_ack;
            end
            EN_MOVE: begin
                mem_req     = 1'b1;
                mem_we      = (32'(sel_q) < N_IN);
                mem_addr    = cur_addr[sel_q];
                mem_wdata   = xfer_wdata;
                xfer_ack    = mem_ack;
                xfer_rdata  = mem_rdata;
                step[sel_q] = mem_ack;
            end
            EN_POSWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pb_base + (32'(sel_q) << 3);
                mem_wdata = lpib[sel_q];
            end
            EN_REFUSE: xfer_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/stream_pos_tracker.sv
module stream_pos_tracker
    import spt_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_OUT    = 4,
    parameter int LVI_W    = 8,
    parameter int ADDR_W   = 14,
    parameter int CFG_ADDR = 'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              xfer_req,
    input  logic              xfer_dir,
    input  logic [3:0]        xfer_tag,
    input  logic [31:0]       xfer_wdata,
    output logic              xfer_ack,
    output logic              xfer_err,
    output logic [31:0]       xfer_rdata
);
    localparam int NS    = N_IN + N_OUT;
    localparam int SEL_W = $clog2(NS);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    logic             w_hit, w_alias, r_hit, r_alias;
    logic [SEL_W-1:0] w_idx, r_idx;
    reg_fld_e         w_fld, r_fld;

    logic [NS-1:0]       lane_need, lane_run, ld_vec, step_vec;
    logic [NS-1:0][3:0]  lane_tag;
    logic [NS-1:0][31:0] lane_pos, lane_cur, lane_fetch;
    logic [NS-1:0][31:0] lane_ctl, lane_sts, lane_lvi, lane_base;
    logic [31:0]         ld_addr, ld_len;
    logic                ld_ioc;
    logic                pb_en;
    logic [31:3]         pb_base_q;

    spt_addr_dec #(.ADDR_W(ADDR_W), .NS(NS)) u_wdec (
        .addr(reg_wr_addr), .hit(w_hit), .is_alias(w_alias), .idx(w_idx), .fld(w_fld)
    );
    spt_addr_dec #(.ADDR_W(ADDR_W), .NS(NS)) u_rdec (
        .addr(reg_rd_addr), .hit(r_hit), .is_alias(r_alias), .idx(r_idx), .fld(r_fld)
    );

    for (genvar g = 0; g < NS; g++) begin : g_lane
        spt_lane #(.LVI_W(LVI_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr_en && w_hit && !w_alias && w_idx == SEL_W'(g)),
            .wr_fld(w_fld), .wr_data(reg_wr_data),
            .ld(ld_vec[g]), .ld_addr(ld_addr), .ld_len(ld_len), .ld_ioc(ld_ioc),
            .step(step_vec[g]),
            .run(lane_run[g]), .tag(lane_tag[g]), .need_fetch(lane_need[g]),
            .lpib(lane_pos[g]), .cur_addr(lane_cur[g]), .fetch_addr(lane_fetch[g]),
            .ctl_word(lane_ctl[g]), .sts_word(lane_sts[g]),
            .lvi_word(lane_lvi[g]), .base_word(lane_base[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_en     <= 1'b0;
            pb_base_q <= '0;
        end else if (reg_wr_en && reg_wr_addr == CFG_A) begin
            pb_en     <= reg_wr_data[0];
            pb_base_q <= reg_wr_data[31:3];
        end
    end

    spt_engine #(.N_IN(N_IN), .N_OUT(N_OUT)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .need_fetch(lane_need), .run(lane_run), .tag(lane_tag),
        .cur_addr(lane_cur), .fetch_addr(lane_fetch), .lpib(lane_pos),
        .pb_en(pb_en), .pb_base({pb_base_q, 3'b000}),
        .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_tag(xfer_tag),
        .xfer_wdata(xfer_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ld(ld_vec), .ld_addr(ld_addr), .ld_len(ld_len), .ld_ioc(ld_ioc),
        .step(step_vec), .xfer_ack(xfer_ack), .xfer_err(xfer_err), .xfer_rdata(xfer_rdata)
    );

    always_comb begin
        reg_rd_data = '0;
        if (reg_rd_addr == CFG_A) begin
            reg_rd_data = {pb_base_q, 2'b00, pb_en};
        end else if (r_hit) begin
            unique case (r_fld)
                FLD_CTL:  reg_rd_data = lane_ctl[r_idx];
                FLD_POS:  reg_rd_data = lane_pos[r_idx];
                FLD_STS:  reg_rd_data = lane_sts[r_idx];
                FLD_LVI:  reg_rd_data = lane_lvi[r_idx];
                FLD_BASE: reg_rd_data = lane_base[r_idx];
                default:  reg_rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter int NS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                xfer_ack,
    input logic                xfer_err,
    input logic                mem_req,
    input logic                mem_ack,
    input logic [NS-1:0]       step_vec,
    input logic [NS-1:0][31:0] pos_all
);
    logic pos_misaligned;
    always_comb begin
        pos_misaligned = 1'b0;
        for (int i = 0; i < NS; i++) pos_misaligned |= |pos_all[i][1:0];
    end

    AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_ack && xfer_err)); // R8
    AST_REFUSE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> !mem_req); // R8
    AST_ACK_WITH_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> (mem_req && mem_ack)); // R3
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> !xfer_ack); // R3
    AST_ONE_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_vec)); // R3
    AST_POS_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_misaligned); // R4
endmodule

bind stream_pos_tracker spt_checker #(.NS(N_IN + N_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
    .mem_req(mem_req), .mem_ack(mem_ack), .step_vec(step_vec), .pos_all(lane_pos)
);

// File: tb/stream_pos_tracker_tb.sv
`timescale 1ns/1ps
module stream_pos_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [13:0] reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [13:0] reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xfer_req = 1'b0, xfer_dir = 1'b0;
    logic [3:0]  xfer_tag = '0;
    logic [31:0] xfer_wdata = '0;
    logic        xfer_ack, xfer_err;
    logic [31:0] xfer_rdata;

    logic [31:0] mem [0:1023];
    logic [31:0] exp_q [$];
    int total = 0;
    int bad = 0;
    logic got_err;

    always #2 clk = ~clk;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;

    stream_pos_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_dir(xfer_dir),
        .xfer_tag(xfer_tag), .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack),
        .xfer_err(xfer_err), .xfer_rdata(xfer_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: output-direction words are popped and compared
    always @(negedge clk) begin
        if (rst_n && xfer_ack && xfer_dir) begin
            if (exp_q.size() == 0) check("R3", "unexpected word", xfer_rdata, 32'hx);
            else check("R3", "output word", xfer_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    // driver: issues one request; for output words the expected value is queued
    task automatic xfer(input logic dir, input logic [3:0] tg,
                        input logic [31:0] wd, input logic [31:0] expw);
        @(negedge clk);
        if (dir) exp_q.push_back(expw);
        xfer_req = 1'b1; xfer_dir = dir; xfer_tag = tg; xfer_wdata = wd;
        got_err = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (xfer_ack || xfer_err) begin
                got_err = xfer_err;
                break;
            end
        end
        xfer_req = 1'b0;
        if (got_err && dir) void'(exp_q.pop_back());
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        // output stream 4 list at 0x100: e0 0x400 len 8, e1 0x500 len 4 flagged
        mem['h100 >> 2] = 32'h400; mem['h104 >> 2] = 32'hFFFF_FFFF;
        mem['h108 >> 2] = 32'd8;   mem['h10C >> 2] = 32'd0;
        mem['h110 >> 2] = 32'h500; mem['h114 >> 2] = 32'hFFFF_FFFF;
        mem['h118 >> 2] = 32'd4;   mem['h11C >> 2] = 32'd1;
        mem['h400 >> 2] = 32'hA0A0_0000; mem['h404 >> 2] = 32'hA1A1_0001;
        mem['h500 >> 2] = 32'hB0B0_0000;
        // input stream 1 list at 0x200: one entry 0x600 len 12 flagged
        mem['h200 >> 2] = 32'h600; mem['h208 >> 2] = 32'd12; mem['h20C >> 2] = 32'd1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(14'h104, v); check("R1", "reset pos s4", v, 0);
        rd(14'h108, v); check("R1", "reset status s4", v, 0);
        rd(14'h100, v); check("R1", "reset ctl s4", v, 0);
        check("R1", "reset mem_req", {31'h0, mem_req}, 0);

        // R8: tag 0 is refused
        xfer(1'b1, 4'd0, 0, 0);
        check("R8", "tag0 refused", {31'h0, got_err}, 1);

        wr(14'h10C, 32'd1);
        wr(14'h110, 32'h100);
        wr(14'h100, 32'h0030_0002);
        xfer(1'b1, 4'd3, 0, 32'hA0A0_0000);
        rd(14'h104, v); check("R4", "pos after 1 word", v, 4);
        rd(14'h2104, v); check("R9", "alias equals pos", v, 4);
        xfer(1'b1, 4'd3, 0, 32'hA1A1_0001);
        rd(14'h104, v); check("R5", "pos crossing entry", v, 8);
        rd(14'h108, v); check("R5", "no flag on unflagged entry", v, 0);
        xfer(1'b1, 4'd3, 0, 32'hB0B0_0000);
        rd(14'h104, v); check("R6", "pos wrapped", v, 0);
        rd(14'h108, v); check("R5", "flag on flagged entry", v, 32'h4);
        xfer(1'b1, 4'd3, 0, 32'hA0A0_0000);
        rd(14'h104, v); check("R6", "restart at entry 0", v, 4);
        wr(14'h108, 32'h0);
        rd(14'h108, v); check("R13", "write 0 keeps flag", v, 32'h4);
        wr(14'h108, 32'h4);
        rd(14'h108, v); check("R13", "W1C clears flag", v, 0);

        // input stream 1, same tag, other direction
        wr(14'h0AC, 32'd0);
        wr(14'h0B0, 32'h200);
        wr(14'h0A0, 32'h0030_0002);
        xfer(1'b0, 4'd3, 32'hC0C0_0000, 0);
        check("R3", "input word written", mem['h600 >> 2], 32'hC0C0_0000);
        rd(14'h0A4, v); check("R7", "input stream advanced", v, 4);
        rd(14'h104, v); check("R7", "output stream untouched", v, 4);

        // position buffer
        wr(14'h070, 32'h801);
        xfer(1'b0, 4'd3, 32'hC1C1_0001, 0);
        check("R10", "posbuf slot s1", mem['h808 >> 2], 8);
        xfer(1'b0, 4'd3, 32'hC2C2_0002, 0);
        check("R10", "posbuf wrap value", mem['h808 >> 2], 0);
        check("R3", "third input word", mem['h608 >> 2], 32'hC2C2_0002);
        rd(14'h0A8, v); check("R6", "input wrap sets flag", v, 32'h4);
        wr(14'h070, 32'h0);

        // stop, refuse, restart
        wr(14'h100, 32'h0030_0000);
        xfer(1'b1, 4'd3, 0, 0);
        check("R12", "stopped stream refused", {31'h0, got_err}, 1);
        rd(14'h104, v); check("R8", "refusal keeps pos", v, 4);
        wr(14'h100, 32'h0030_0002);
        rd(14'h104, v); check("R12", "start clears pos", v, 0);
        xfer(1'b1, 4'd3, 0, 32'hA0A0_0000);
        rd(14'h104, v); check("R12", "pos after restart word", v, 4);
        check("R2", "scoreboard drained", exp_q.size(), 0);

        // stream reset
        wr(14'h0A0, 32'h0030_0003);
        rd(14'h0A0, v); check("R11", "srst held", v, 32'h1);
        rd(14'h0A8, v); check("R11", "fifo ready set", v, 32'h20);
        rd(14'h0A4, v); check("R11", "pos cleared", v, 0);
        rd(14'h0B0, v); check("R11", "base cleared", v, 0);
        xfer(1'b0, 4'd3, 32'h1, 0);
        check("R11", "reset stream refuses", {31'h0, got_err}, 1);
        wr(14'h0A0, 32'h0);
        rd(14'h0A0, v); check("R11", "srst released", v, 0);

        finish_up();
    end
endmodule